// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master for PHY devices on a two-wire management bus. It generates the management clock and shifts out framed read and write transactions. For reads, it captures the 16-bit register value returned by the PHY. The host starts a transaction with a one-cycle `start` strobe. Along with the strobe it gives a direction bit, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. When the frame is over, the block gives a single-cycle `done` pulse.

The data line appears as three signals: an output value, an output enable and an input. The tristate pad sits outside the block. The management clock runs from a counter that holds each clock phase for `HALF_PERIOD` system clocks. The input passes through a synchronizer before it is sampled.

A read can target an address where no PHY is present. In that case nothing drives the turnaround bit low. The block then clocks the bus for 32 more periods with the line released, and reports all ones together with an error flag.

Top module: `mgmt_mdio_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mdc` is 1, `mdio_oe` is 0, `done` is 0, and `rd_data`/`err` are 0 until the first frame completes.
- R2: Within a frame, every low phase and every high phase of `mdc` lasts exactly `HALF_PERIOD` system clocks. A bit period is one low phase followed by one high phase, and the frame begins with `mdc` falling in the cycle after `start` is accepted.
- R3: Bit periods 0 to 31 form a preamble in which `mdio_oe`=1 and `mdio_o`=1.
- R4: Periods 32 and 33 carry 0 then 1. Periods 34 and 35 carry the opcode: 1,0 when `rd_wr`=1 (read) and 0,1 when `rd_wr`=0 (write).
- R5: Periods 36 to 40 carry `phy_addr` and periods 41 to 45 carry `reg_addr`, each most significant bit first.
- R6: `mdio_o` and `mdio_oe` change only in a cycle where `mdc` is low.
- R7: A write drives 1 then 0 in periods 46 and 47, then `wr_data` MSB first in periods 48 to 63. In period 64 the line is released. The frame lasts 65 periods, and at its end `err` is 0 and `rd_data` is unchanged.
- R8: A read releases the line from period 46 on. The level at the end of the high phase of period 46 decides whether a PHY is present: 0 means present. Data bits are taken at the end of the high phases of periods 47 to 62, MSB first. One extra period (63) follows, so the frame lasts 64 periods, and `err` is 0.
- R9: If the period-46 sample is 1, the line stays released for periods 47 to 78, so the frame lasts 79 periods. `rd_data` is then 16'hFFFF and `err` is 1.
- R10: `done` is high for exactly one cycle at the end of a frame, with `mdc` high and `mdio_oe` low. `rd_data` and `err` hold their values until the next frame ends.
- R11: A `start` that arrives while a frame is in progress has no effect on the frame on the wire or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a frame |
| rd_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write frame |
| rd_data | output | 16 | Result of the last read (all ones when no PHY answered) |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last read found no PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
The hardest case to reach from the ports is a turnaround bit left undriven, followed by the long released flush. A PHY model in the bench follows the falling edges of `mdc` and counts bit periods. It can be switched to act as an absent device, so the line floats high through period 46 and on to the end of the flush. The same model drives the turnaround low and shifts out a chosen word for the present case. A few data words are picked to start or end with a 1 next to the turnaround, which catches an off-by-one sampling point. A second strobe is injected partway through both a read and a write to show that the frame in flight is untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int PRE_LEN = 32;
  localparam int IDX_W   = 7;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic oe;
    logic o;
  } drv_t;

  // Bit-period positions inside a frame
  localparam idx_t ST0_IDX    = idx_t'(PRE_LEN);
  localparam idx_t ST1_IDX    = idx_t'(PRE_LEN + 1);
  localparam idx_t OP0_IDX    = idx_t'(PRE_LEN + 2);
  localparam idx_t OP1_IDX    = idx_t'(PRE_LEN + 3);
  localparam idx_t PHY_IDX    = idx_t'(PRE_LEN + 4);
  localparam idx_t REG_IDX    = idx_t'(PRE_LEN + 4 + ADDR_W);
  localparam idx_t TA_IDX     = idx_t'(PRE_LEN + 4 + 2*ADDR_W);
  localparam idx_t TA1_IDX    = idx_t'(PRE_LEN + 5 + 2*ADDR_W);
  localparam idx_t RD_LAST    = idx_t'(PRE_LEN + 5 + 2*ADDR_W + DATA_W);
  localparam idx_t WR_LAST    = idx_t'(PRE_LEN + 6 + 2*ADDR_W + DATA_W);
  localparam idx_t FLUSH_LAST = idx_t'(2*PRE_LEN + 4 + 2*ADDR_W);
  localparam idx_t PHY_MSB    = idx_t'(PRE_LEN + 3 + ADDR_W);
  localparam idx_t REG_MSB    = idx_t'(PRE_LEN + 3 + 2*ADDR_W);
  localparam idx_t WD_MSB     = idx_t'(PRE_LEN + 5 + 2*ADDR_W + DATA_W);

  // Line state the master presents during a given bit period
  function automatic drv_t frame_drive(idx_t idx, logic rd,
                                       logic [ADDR_W-1:0] phy,
                                       logic [ADDR_W-1:0] rg,
                                       logic [DATA_W-1:0] wd);
    drv_t d;
    idx_t off;
    d.oe = 1'b1;
    d.o  = 1'b1;
    off  = '0;
    if (idx < ST0_IDX)       d.o = 1'b1;
    else if (idx == ST0_IDX) d.o = 1'b0;
    else if (idx == ST1_IDX) d.o = 1'b1;
    else if (idx == OP0_IDX) d.o = rd;
    else if (idx == OP1_IDX) d.o = ~rd;
    else if (idx < REG_IDX) begin
      off = PHY_MSB - idx;
      d.o = phy[off[2:0]];
    end else if (idx < TA_IDX) begin
      off = REG_MSB - idx;
      d.o = rg[off[2:0]];
    end else if (rd) begin
      d.oe = 1'b0;
    end else if (idx == TA_IDX) d.o = 1'b1;
    else if (idx == TA1_IDX)    d.o = 1'b0;
    else if (idx < WR_LAST) begin
      off = WD_MSB - idx;
      d.o = wd[off[3:0]];
    end else begin
      d.oe = 1'b0;
    end
    return d;
  endfunction

  // Final bit period of a frame
  function automatic idx_t last_idx(logic rd, logic absent);
    if (!rd)    return WR_LAST;
    if (absent) return FLUSH_LAST;
    return RD_LAST;
  endfunction

  // Data bit window of a read (periods after the turnaround, before the tail)
  function automatic logic in_rd_window(idx_t idx);
    return (idx > TA_IDX) && (idx < RD_LAST);
  endfunction
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic stop,
  output logic mdc,
  output logic running,
  output logic bit_edge
);
  localparam int CW = (HALF_PERIOD < 2) ? 1 : $clog2(HALF_PERIOD);
  localparam logic [CW-1:0] CNT_END = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          run_q;
  logic          phase_end;

  assign phase_end = run_q && (cnt_q == CNT_END);
  assign bit_edge  = phase_end && mdc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      mdc_q <= 1'b1;
      cnt_q <= '0;
    end else if (kick && !run_q) begin
      run_q <= 1'b1;
      mdc_q <= 1'b0;
      cnt_q <= '0;
    end else if (phase_end) begin
      cnt_q <= '0;
      if (!mdc_q)    mdc_q <= 1'b1;
      else if (stop) run_q <= 1'b0;
      else           mdc_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc     = mdc_q;
  assign running = run_q;

  // R1: clock rests high outside a frame
  a_r1_idle_mdc_high: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> mdc_q);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              running,
  input  logic              bit_edge,
  input  logic              line_in,
  output logic              kick,
  output logic              stop,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              err,
  output logic              done
);
  idx_t              idx_q;
  logic              rd_q;
  logic              absent_q;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] reg_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] shift_q;
  drv_t              next_drv;

  assign kick     = start && !running;
  assign stop     = (idx_q == last_idx(rd_q, absent_q));
  assign next_drv = frame_drive(idx_q + 1'b1, rd_q, phy_q, reg_q, wd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      rd_q     <= 1'b0;
      absent_q <= 1'b0;
      phy_q    <= '0;
      reg_q    <= '0;
      wd_q     <= '0;
      shift_q  <= '0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (kick) begin
        idx_q    <= '0;
        rd_q     <= rd_wr;
        absent_q <= 1'b0;
        phy_q    <= phy_addr;
        reg_q    <= reg_addr;
        wd_q     <= wr_data;
        mdio_oe  <= 1'b1;
        mdio_o   <= 1'b1;
      end else if (bit_edge) begin
        if (stop) begin
          done    <= 1'b1;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
          err     <= rd_q && absent_q;
          if (rd_q) rd_data <= absent_q ? '1 : shift_q;
        end else begin
          idx_q   <= idx_q + 1'b1;
          mdio_oe <= next_drv.oe;
          mdio_o  <= next_drv.o;
          if (rd_q) begin
            if (idx_q == TA_IDX)
              absent_q <= line_in;
            else if (!absent_q && in_rd_window(idx_q))
              shift_q <= {shift_q[DATA_W-2:0], line_in};
          end
        end
      end
    end
  end

  // R10: end-of-frame pulse lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: line released when the frame is reported over
  a_r10_done_released: assert property (@(posedge clk) disable iff (rst)
    done |-> !mdio_oe);
  // R9: an absent PHY always reports all ones
  a_r9_absent_ones: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rd_data == '1));
  // R11: a strobe during a frame leaves the captured request alone
  a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (running && start) |=> ($stable(phy_q) && $stable(reg_q) && $stable(rd_q) && $stable(wd_q)));
endmodule

// File: rtl/mgmt_mdio_master.sv
module mgmt_mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_PERIOD = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic kick;
  logic stop;
  logic running;
  logic bit_edge;
  logic line_in;

  mdio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (mdio_i),
    .dout (line_in)
  );

  mdio_clkgen #(.HALF_PERIOD(HALF_PERIOD)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .kick     (kick),
    .stop     (stop),
    .mdc      (mdc),
    .running  (running),
    .bit_edge (bit_edge)
  );

  mdio_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_wr    (rd_wr),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .running  (running),
    .bit_edge (bit_edge),
    .line_in  (line_in),
    .kick     (kick),
    .stop     (stop),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data),
    .err      (err),
    .done     (done)
  );

  // R6: the data line moves only while the clock is low
  a_r6_change_when_low: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);
endmodule

// File: tb/tb_mgmt_mdio_master.sv
module tb_mgmt_mdio_master;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_wr = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        done, err, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mgmt_mdio_master #(.HALF_PERIOD(HALF), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .start(start), .rd_wr(rd_wr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .done(done), .err(err), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // line monitor and PHY model
  logic        mdc_prev = 1'b1;
  int          nrise = 0, nfall = 0, plen = 0, bad_phase = 0;
  bit          have_edge = 0;
  logic        rec_oe [0:99];
  logic        rec_o  [0:99];
  bit          phy_present = 0;
  logic [15:0] phy_val = '0;

  // expected frame
  int   exp_n;
  logic exp_oe [0:99];
  logic exp_o  [0:99];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    plen++;
    if (mdc !== mdc_prev) begin
      if (have_edge && plen != HALF) bad_phase++;
      have_edge = 1;
      plen = 0;
      if (mdc === 1'b1) begin
        if (nrise < 100) begin
          rec_oe[nrise] = mdio_oe;
          rec_o[nrise]  = mdio_o;
        end
        nrise++;
      end else begin
        if (phy_present && nfall == 46) mdio_i = 1'b0;
        else if (phy_present && nfall >= 47 && nfall <= 62) mdio_i = phy_val[62 - nfall];
        else mdio_i = 1'b1;
        nfall++;
      end
    end
    mdc_prev = mdc;
  end

  task automatic push(input logic oe, input logic o);
    exp_oe[exp_n] = oe;
    exp_o[exp_n]  = o;
    exp_n++;
  endtask

  task automatic build_exp(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input bit present);
    exp_n = 0;
    for (int i = 0; i < 32; i++) push(1, 1);
    push(1, 0); push(1, 1);
    if (rd) begin push(1, 1); push(1, 0); end
    else    begin push(1, 0); push(1, 1); end
    for (int i = 4; i >= 0; i--) push(1, pa[i]);
    for (int i = 4; i >= 0; i--) push(1, ra[i]);
    if (rd) begin
      int tail = present ? 18 : 33;
      for (int i = 0; i < tail; i++) push(0, 1);
    end else begin
      push(1, 1); push(1, 0);
      for (int i = 15; i >= 0; i--) push(1, wd[i]);
      push(0, 1);
    end
  endtask

  task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input bit present, input bit poke);
    logic [15:0] prev_rd = rd_data;
    int  mism = 0, first_bad = -1, wait_n = 0, dwidth = 0;
    bit  seen = 0;
    build_exp(rd, pa, ra, wd, present);
    phy_present = present;
    phy_val     = wd;
    @(negedge clk);
    nrise = 0; nfall = 0; have_edge = 0; bad_phase = 0;
    rd_wr = rd; phy_addr = pa; reg_addr = ra; wr_data = rd ? 16'h0 : wd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen && wait_n < 2000) begin
      if (poke && wait_n == 150) begin
        rd_wr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      wait_n++;
      if (done) seen = 1;
    end
    start = 1'b0;
    chk(seen, "R10 done seen", seen, 1);
    if (!seen) return;
    chk(mdc === 1'b1 && mdio_oe === 1'b0, "R10 idle line at done", {mdc, mdio_oe}, 2'b10);
    dwidth = 1;
    @(negedge clk);
    if (done) dwidth++;
    chk(dwidth == 1, "R10 done width", dwidth, 1);
    chk(nrise == exp_n, rd ? (present ? "R8 period count" : "R9 period count") : "R7 period count",
        nrise, exp_n);
    for (int i = 0; i < exp_n && i < 100; i++) begin
      if (rec_oe[i] !== exp_oe[i] || (exp_oe[i] && rec_o[i] !== exp_o[i])) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    end
    chk(mism == 0, poke ? "R11 frame bits with busy start" : "R3 R4 R5 R7 R8 frame bits",
        first_bad, -1);
    chk(bad_phase == 0, "R2 phase length", bad_phase, 0);
    if (rd) begin
      chk(rd_data === (present ? wd : 16'hFFFF), present ? "R8 read data" : "R9 read data",
          rd_data, present ? wd : 16'hFFFF);
      chk(err === !present, present ? "R8 err clear" : "R9 err set", err, !present);
    end else begin
      chk(rd_data === prev_rd && err === 1'b0, "R7 write result", {err, rd_data}, {1'b0, prev_rd});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] hold_v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(mdc === 1'b1 && mdio_oe === 1'b0 && done === 1'b0, "R1 reset line", {mdc, mdio_oe, done}, 3'b100);
    chk(rd_data === 16'h0 && err === 1'b0, "R1 reset result", {err, rd_data}, 0);
    repeat (10) @(negedge clk);
    chk(mdc === 1'b1 && mdio_oe === 1'b0, "R1 idle without start", {mdc, mdio_oe}, 2'b10);

    // write sweep over all PHY addresses
    for (int p = 0; p < 32; p++)
      run_frame(0, 5'(p), 5'(31 - p), 16'((p * 16'h0841) ^ 16'hA5C3), 1, 0);

    // reads with a present PHY
    run_frame(1, 5'h01, 5'h02, 16'h0000, 1, 0);
    run_frame(1, 5'h1F, 5'h00, 16'hFFFF, 1, 0);
    run_frame(1, 5'h10, 5'h11, 16'h8001, 1, 0);
    run_frame(1, 5'h0A, 5'h15, 16'h7FFE, 1, 0);
    for (int k = 0; k < 8; k++)
      run_frame(1, 5'(k * 3), 5'(k * 5), 16'(16'h1234 * (k + 1)), 1, 0);

    // R10 results hold while idle
    hold_v = rd_data;
    repeat (30) @(negedge clk);
    chk(rd_data === hold_v && err === 1'b0, "R10 result holds", rd_data, hold_v);

    // absent PHY
    run_frame(1, 5'h05, 5'h01, 16'h0000, 0, 0);
    repeat (30) @(negedge clk);
    chk(rd_data === 16'hFFFF && err === 1'b1, "R10 error holds", {err, rd_data}, 17'h1FFFF);
    run_frame(1, 5'h1E, 5'h1F, 16'h5555, 0, 0);
    // a write clears the error and keeps read data
    run_frame(0, 5'h03, 5'h04, 16'hC0DE, 1, 0);
    run_frame(1, 5'h00, 5'h00, 16'hAAAA, 0, 0);
    // a present read after an absent one
    run_frame(1, 5'h02, 5'h09, 16'h4B1D, 1, 0);

    // R11 strobes during a frame
    run_frame(0, 5'h0C, 5'h0D, 16'h3C96, 1, 1);
    run_frame(1, 5'h13, 5'h07, 16'hE817, 1, 1);
    run_frame(1, 5'h09, 5'h0E, 16'h0000, 0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule